// File: doc/BRIEF.md
# Slow-Tick 24-bit Down-Counting Timer

This block is a programmable down-counter intended for a low-frequency time base. It advances only on cycles where an external slow-tick enable (for example a 32 kHz strobe resynchronised into the system clock) is high. Software programs a 24-bit reload value, starts the counter through a control register and may read the live count at any time. When the count is exhausted, the block emits a single-cycle interrupt pulse if interrupts are enabled. It then either reloads and keeps running, or stops.

Access is through a simple synchronous register bus. A write takes effect at the clock edge where select and write are both high. Read data is a combinational function of the byte address. Three word registers are decoded: reload at byte address 0x0, live count at 0x4 and control at 0x8. Any other address reads as zero. A write to the control register only restarts the counter when the start request differs from the present run state, or when the force-reload bit is written as 1. This lets software change the interrupt and auto-reload settings without disturbing a running count.

Top module: `lf_os_timer`

## Requirements
- R1: A write to address 0x0 stores bits 23:0 of the write data as the reload value. A read of 0x0 returns that value with bits 31:24 as zero. Changing the reload value does not alter the count until the next reload.
- R2: A read of address 0x4 returns the live 24-bit count, zero-extended. Writes to 0x4 have no effect on any register.
- R3: The control register at 0x8 has these fields: bit 3 selects auto-reload, bit 2 enables the interrupt and bit 0 is start. Reads return the current values in those positions; bit 1 and all other bits read 0. Every control write updates bits 3 and 2.
- R4: A control write reloads the count from the reload register and sets the run state to written bit 0 only when written bit 0 differs from the current start bit, or when written bit 1 is 1. Otherwise the count and run state are unchanged.
- R5: After synchronous active-low reset the timer is stopped. Interrupts are disabled, auto-reload is 1, the reload value is 0xFFFFFF and the count is 0, so control reads 0x8.
- R6: While running, the count drops by one on each clock where the tick enable is high. While stopped, the count holds.
- R7: A tick that finds the count at 0 while running is an expiry. It raises the interrupt output for exactly the following clock cycle when interrupts are enabled, and raises nothing when they are disabled.
- R8: On expiry with auto-reload 1, the count takes the reload value and the timer keeps running. With auto-reload 0, the timer stops, start reads 0 and the count stays 0.
- R9: When a restarting control write and a tick fall in the same cycle, the restart wins. The count becomes the reload value with no decrement and no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Slow-tick enable, one clock wide per tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_pulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The hardest situation to reach is a restarting control write that lands in the same clock as a tick on a running counter. The vector table cannot line the two up, so a directed step drives the bus write and the tick enable on the same falling edge. It then reads back the count and expects the untouched reload value. A second hard case is a reload value of zero with auto-reload on, where every tick is an expiry. A directed run of consecutive ticks checks that one interrupt is counted per tick while the count stays at zero.

// File: rtl/lfot_pkg.sv
// Package: shared register addresses, control bit positions and the
// configuration struct of the slow-tick timer. Assumes byte addressing.
package lfot_pkg;
    localparam int unsigned OFS_RELOAD = 0;
    localparam int unsigned OFS_COUNT  = 4;
    localparam int unsigned OFS_CTRL   = 8;

    localparam int unsigned CTL_START  = 0;
    localparam int unsigned CTL_FORCE  = 1;
    localparam int unsigned CTL_IE     = 2;
    localparam int unsigned CTL_AR     = 3;

    typedef struct packed {
        logic ar;   // reload on expiry
        logic ie;   // interrupt enable
    } lfot_cfg_t;
endpackage

// File: rtl/lfot_regs.sv
// Module: register file of the timer. Holds the reload value and the
// auto-reload / interrupt-enable settings, and decides whether a control
// write restarts the counter. Assumes writes are single-cycle strobes.
module lfot_regs
    import lfot_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              run_i,
    output logic [CNT_W-1:0]  reload_o,
    output lfot_cfg_t         cfg_o,
    output logic              restart_o,
    output logic              restart_run_o
);
    localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] reload_q;
    lfot_cfg_t        cfg_q;
    logic             wr_reload;
    logic             wr_ctrl;
    logic             unused_hi;

    // Decode of write strobes per register.
    always_comb begin
        wr_reload = sel_i && wr_i && (addr_i == ADDR_W'(OFS_RELOAD));
        wr_ctrl   = sel_i && wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    end

    // Restart decision: start bit changes or force bit written as 1.
    always_comb begin
        restart_o     = wr_ctrl && ((wdata_i[CTL_START] != run_i) || wdata_i[CTL_FORCE]);
        restart_run_o = wdata_i[CTL_START];
    end

    // Reload value storage, low CNT_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= RELOAD_RST;
        else if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
    end

    // Configuration bits, refreshed on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.ar <= 1'b1;
            cfg_q.ie <= 1'b0;
        end else if (wr_ctrl) begin
            cfg_q.ar <= wdata_i[CTL_AR];
            cfg_q.ie <= wdata_i[CTL_IE];
        end
    end

    assign reload_o  = reload_q;
    assign cfg_o     = cfg_q;
    assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];

    // R1
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && wr_i && addr_i == ADDR_W'(OFS_RELOAD)) |=> $stable(reload_q));
endmodule

// File: rtl/lfot_core.sv
// Module: the down-counter and run state. Counts on tick enables, detects
// expiry, reloads or stops, and registers the interrupt pulse. Assumes a
// restart request from the register file takes priority over a tick.
module lfot_core
    import lfot_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             restart_run_i,
    input  logic [CNT_W-1:0] reload_i,
    input  lfot_cfg_t        cfg_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic             irq_q;
    logic             expire;

    // Expiry: running tick that finds the count at zero.
    always_comb expire = run_q && tick_i && !restart_i && (count_q == '0);

    // Counter and run state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (restart_i) begin
            count_q <= reload_i;
            run_q   <= restart_run_i;
        end else if (expire) begin
            if (cfg_i.ar) count_q <= reload_i;
            else          run_q   <= 1'b0;
        end else if (run_q && tick_i) begin
            count_q <= count_q - 1'b1;
        end
    end

    // One-cycle interrupt pulse following an enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && cfg_i.ie;
    end

    assign count_o = count_q;
    assign run_o   = run_q;
    assign irq_o   = irq_q;

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !restart_i && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !restart_i) |=> $stable(count_q));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(cfg_i.ie));

    // R8
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !restart_i && count_q == '0 && !cfg_i.ar) |=> !run_q);

    // R9
    restart_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> count_q == $past(reload_i));
endmodule

// File: rtl/lfot_rdmux.sv
// Module: read-data selection. Purely combinational, zero-extends the
// 24-bit values and packs the control bits. Unmapped addresses read 0.
module lfot_rdmux
    import lfot_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  count_i,
    input  lfot_cfg_t         cfg_i,
    input  logic              run_i,
    output logic [DATA_W-1:0] rdata_o
);
    // Address decode into the read word.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_RELOAD)) begin
            rdata_o[CNT_W-1:0] = reload_i;
        end else if (addr_i == ADDR_W'(OFS_COUNT)) begin
            rdata_o[CNT_W-1:0] = count_i;
        end else if (addr_i == ADDR_W'(OFS_CTRL)) begin
            rdata_o[CTL_AR]    = cfg_i.ar;
            rdata_o[CTL_IE]    = cfg_i.ie;
            rdata_o[CTL_START] = run_i;
        end
    end
endmodule

// File: rtl/lf_os_timer.sv
// Module: top of the slow-tick 24-bit timer. Connects register file,
// counter core and read mux. Assumes tick_en is already synchronous to clk.
module lf_os_timer
    import lfot_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    lfot_cfg_t        cfg_w;
    logic             run_w;
    logic             restart_w;
    logic             restart_run_w;

    lfot_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_i         (bus_sel),
        .wr_i          (bus_wr),
        .addr_i        (bus_addr),
        .wdata_i       (bus_wdata),
        .run_i         (run_w),
        .reload_o      (reload_w),
        .cfg_o         (cfg_w),
        .restart_o     (restart_w),
        .restart_run_o (restart_run_w)
    );

    lfot_core #(.CNT_W(CNT_W)) core_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_en),
        .restart_i     (restart_w),
        .restart_run_i (restart_run_w),
        .reload_i      (reload_w),
        .cfg_i         (cfg_w),
        .count_o       (count_w),
        .run_o         (run_w),
        .irq_o         (irq_pulse)
    );

    lfot_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) rdmux_i (
        .addr_i   (bus_addr),
        .reload_i (reload_w),
        .count_i  (count_w),
        .cfg_i    (cfg_w),
        .run_i    (run_w),
        .rdata_o  (bus_rdata)
    );
endmodule

// File: tb/lf_os_timer_tb_top.sv
// Bench: table of bus/tick operations walked by one loop, then directed
// tests for same-cycle restart, zero reload and reset.
module lf_os_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 40;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

    // entry: [73:70] req, [69:68] op, [67:64] addr, [63:32] arg, [31:0] expected
    localparam logic [73:0] VEC [0:NV-1] = '{
        {4'd5,  OP_RD,  4'h0, 32'h0,        32'h00FFFFFF}, // R5
        {4'd5,  OP_RD,  4'h4, 32'h0,        32'h0},        // R5
        {4'd5,  OP_RD,  4'h8, 32'h0,        32'h8},        // R5
        {4'd1,  OP_WR,  4'h0, 32'hAB000005, 32'h0},        // R1
        {4'd1,  OP_RD,  4'h0, 32'h0,        32'h5},        // R1
        {4'd2,  OP_WR,  4'h4, 32'h123,      32'h0},        // R2
        {4'd2,  OP_RD,  4'h4, 32'h0,        32'h0},        // R2
        {4'd4,  OP_WR,  4'h8, 32'h5,        32'h0},        // R4 start
        {4'd3,  OP_RD,  4'h8, 32'h0,        32'h5},        // R3
        {4'd6,  OP_TK,  4'h0, 32'd3,        32'h0},        // R6
        {4'd6,  OP_RD,  4'h4, 32'h0,        32'h2},        // R6
        {4'd8,  OP_TK,  4'h0, 32'd3,        32'h0},        // R8 one-shot expiry
        {4'd8,  OP_RD,  4'h4, 32'h0,        32'h0},        // R8
        {4'd8,  OP_RD,  4'h8, 32'h0,        32'h4},        // R8
        {4'd7,  OP_IRQ, 4'h0, 32'h0,        32'h1},        // R7
        {4'd4,  OP_WR,  4'h8, 32'hD,        32'h0},        // R4
        {4'd8,  OP_TK,  4'h0, 32'd6,        32'h0},        // R8 periodic
        {4'd8,  OP_RD,  4'h4, 32'h0,        32'h5},        // R8
        {4'd7,  OP_IRQ, 4'h0, 32'h0,        32'h1},        // R7
        {4'd8,  OP_RD,  4'h8, 32'h0,        32'hD},        // R8
        {4'd3,  OP_WR,  4'h8, 32'h9,        32'h0},        // R3
        {4'd3,  OP_RD,  4'h8, 32'h0,        32'h9},        // R3
        {4'd4,  OP_RD,  4'h4, 32'h0,        32'h5},        // R4 no restart
        {4'd1,  OP_WR,  4'h0, 32'h2,        32'h0},        // R1
        {4'd1,  OP_TK,  4'h0, 32'd2,        32'h0},        // R1
        {4'd1,  OP_RD,  4'h4, 32'h0,        32'h3},        // R1 count untouched
        {4'd4,  OP_WR,  4'h8, 32'hB,        32'h0},        // R4 force
        {4'd4,  OP_RD,  4'h4, 32'h0,        32'h2},        // R4
        {4'd3,  OP_RD,  4'h8, 32'h0,        32'h9},        // R3 force reads 0
        {4'd7,  OP_TK,  4'h0, 32'd3,        32'h0},        // R7
        {4'd7,  OP_IRQ, 4'h0, 32'h0,        32'h0},        // R7 disabled
        {4'd8,  OP_RD,  4'h4, 32'h0,        32'h2},        // R8
        {4'd4,  OP_WR,  4'h8, 32'h8,        32'h0},        // R4 stop
        {4'd6,  OP_TK,  4'h0, 32'd4,        32'h0},        // R6
        {4'd6,  OP_RD,  4'h4, 32'h0,        32'h2},        // R6 holds
        {4'd4,  OP_RD,  4'h8, 32'h0,        32'h8},        // R4
        {4'd1,  OP_WR,  4'h0, 32'h7,        32'h0},        // R1
        {4'd4,  OP_WR,  4'h8, 32'hA,        32'h0},        // R4 force while stopped
        {4'd4,  OP_RD,  4'h4, 32'h0,        32'h7},        // R4
        {4'd3,  OP_RD,  4'h8, 32'h0,        32'h8}         // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    int irq_seen = 0;
    bit done     = 1'b0;

    lf_os_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Interrupt pulse counter, sampled on the edge after the pulse rises.
    always @(posedge clk) if (irq_pulse) irq_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic irq_check(input string tag, input int exp);
        repeat (2) @(negedge clk);
        check(tag, 32'(irq_seen), 32'(exp));
        irq_seen = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][69:68])
                OP_WR: bus_write(VEC[i][67:64], VEC[i][63:32]);
                OP_RD: begin
                    bus_read(VEC[i][67:64], rd);
                    check($sformatf("R%0d vec%0d", VEC[i][73:70], i), rd, VEC[i][31:0]);
                end
                OP_TK: do_ticks(int'(VEC[i][63:32]));
                default: irq_check($sformatf("R%0d vec%0d irq", VEC[i][73:70], i), int'(VEC[i][31:0]));
            endcase
        end

        // R9: restart and tick in the same cycle; restart must win.
        bus_write(4'h8, 32'h1);          // start: count = 7, ar=0 ie=0
        do_ticks(2);                     // count = 5
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'hB;
        tick_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        bus_read(4'h4, rd);
        check("R9 same-cycle restart", rd, 32'h7);

        // R7 R8: zero reload with auto-reload, every tick expires.
        irq_seen = 0;
        bus_write(4'h0, 32'h0);
        bus_write(4'h8, 32'hF);
        do_ticks(4);
        irq_check("R7 zero reload pulses", 4);
        bus_read(4'h4, rd);
        check("R8 zero reload count", rd, 32'h0);

        // R5: reset while running restores defaults and stops the count.
        bus_write(4'h0, 32'h9);
        bus_write(4'h8, 32'hF);
        do_ticks(2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        irq_seen = 0;
        bus_read(4'h0, rd);
        check("R5 reload after reset", rd, 32'h00FFFFFF);
        bus_read(4'h8, rd);
        check("R5 ctrl after reset", rd, 32'h8);
        do_ticks(3);
        bus_read(4'h4, rd);
        check("R5 count after reset", rd, 32'h0);
        irq_check("R5 no irq after reset", 0);

        done = 1'b1;
        summary();
    end
endmodule